// File: doc/BRIEF.md
# Clock-Aligned One-Shot Pulse Generator

This block produces a single pulse that is aligned to a divided, trigger-synchronised output clock. It sits beside the clock divider in the system clock domain and sees that clock only through a one-cycle strobe, `ck_rise`, raised in each system cycle where the output clock makes a rising edge. A one-cycle `sync_edge` strobe marks the active trigger edge and arms the generator. The first qualifying output-clock rise after arming starts the pulse. The pulse then lasts a programmed number of output-clock cycles.

In the output-gated trigger modes the output clock can show a short spike rise while it is stopped. The divider flags such a rise with `ck_stopped`, and that rise never starts a pulse. A 2-bit code selects a width of 2, 4, 8 or 16 output-clock cycles, and a polarity bit selects an active-low or an active-high pulse. A sync edge that arrives while a pulse is running is dropped.

Top module: `sync_oneshot`

## Requirements
- R1: A pulse starts only on a `ck_rise` strobe seen in a cycle after the one where `sync_edge` armed the block. `pulse_o` takes its active level in the system cycle that follows that strobe. A rise in the same cycle as the arming `sync_edge` does not start the pulse.
- R2: `width_code` is sampled in the cycle the pulse starts. Code 0 gives 2 output-clock cycles, 1 gives 4, 2 gives 8 and 3 gives 16. Changing the code while a pulse runs does not change that pulse.
- R3: With `pol` = 1 the pulse is high and the idle level is low. With `pol` = 0 the pulse is low and the idle level is high.
- R4: A `ck_rise` strobe that comes with `ck_stopped` = 1 does not start a pulse. The block stays armed, and the next rise with `ck_stopped` = 0 starts the pulse.
- R5: A `sync_edge` is ignored if it arrives while a pulse is active, and also if it arrives in the cycle a pulse starts. It leaves no arming behind once that pulse completes.
- R6: While reset is asserted (active low) and after its release, the block is idle and disarmed: `pulse_o` sits at the inactive level for the current `pol`.
- R7: The width counter decrements on every `ck_rise` strobe while the pulse is active. `pulse_o` returns to idle in the cycle after the N-th such strobe, where N is the selected width.
- R8: Each arming yields at most one pulse. After a pulse completes, no further pulse starts until a new `sync_edge` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ck_rise | input | 1 | One-cycle strobe marking each rising edge of the output clock |
| sync_edge | input | 1 | One-cycle strobe marking the active trigger edge |
| ck_stopped | input | 1 | High when the current rise is only a spike of the stopped clock |
| width_code | input | 2 | Pulse width select: 2, 4, 8 or 16 output-clock cycles |
| pol | input | 1 | Pulse polarity: 1 for an active-high pulse, 0 for active-low |
| pulse_o | output | 1 | One-shot pulse output |

## Verification
The state of the block is a width counter and an arm flag, and a fault in either shows up at `pulse_o` quickly. A lost or stale arm flag gives a missing or extra pulse, or a pulse started on a spike rise. This appears one system cycle after the offending rise strobe. A wrong counter load or decrement moves the trailing edge of the pulse, and the move is visible at the first output-clock rise where the count should have ended. The bench compares `pulse_o` with a behavioural model every cycle. It therefore catches these faults at the exact cycle they first differ, across all widths, both polarities and irregular rise spacing.

// File: rtl/sync_oneshot.sv
module sync_oneshot #(
  parameter int CNT_W = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ck_rise,
  input  logic       sync_edge,
  input  logic       ck_stopped,
  input  logic [1:0] width_code,
  input  logic       pol,
  output logic       pulse_o
);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             busy;
  logic             start;
  logic [CNT_W-1:0] load_val;

  assign busy     = |cnt;
  assign start    = armed & ck_rise & ~ck_stopped & ~busy;
  assign load_val = CNT_W'(2) << width_code;
  assign pulse_o  = ~(busy ^ pol);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (start)
        cnt <= load_val;
      else if (busy && ck_rise)
        cnt <= cnt - 1'b1;
      armed <= start ? 1'b0 : (armed | (sync_edge & ~busy));
    end
  end

  AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(armed && ck_rise && !ck_stopped)); // R1
  AST_LOAD_POW2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($countones(cnt) == 1 && cnt >= CNT_W'(2))); // R2
  AST_SPIKE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && ck_stopped) |=> !busy); // R4
  AST_BUSY_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !armed); // R5
  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ck_rise) |=> $stable(cnt)); // R7
  AST_END_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ck_rise)); // R7
  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (cnt == '0 && !armed)); // R6

endmodule

// File: tb/sim_sync_oneshot.sv
module sim_sync_oneshot;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ck_rise = 1'b0, sync_edge = 1'b0, ck_stopped = 1'b0, pol = 1'b1;
  logic [1:0] width_code = 2'd0;
  logic       pulse_o;

  int    n_vec = 0, n_bad = 0;
  int    ref_left = 0;
  bit    ref_armed = 0;
  string tag = "R6";
  bit    done = 0;

  always #5 clk = ~clk;

  sync_oneshot u0 (.clk(clk), .rst_n(rst_n), .ck_rise(ck_rise), .sync_edge(sync_edge),
                   .ck_stopped(ck_stopped), .width_code(width_code), .pol(pol), .pulse_o(pulse_o));

  always @(posedge clk) begin
    if (!rst_n) begin
      ref_left  <= 0;
      ref_armed <= 0;
    end else if (ref_left > 0) begin
      if (ck_rise) ref_left <= ref_left - 1;
    end else if (ref_armed && ck_rise && !ck_stopped) begin
      ref_left  <= 2 ** (int'(width_code) + 1);
      ref_armed <= 0;
    end else if (sync_edge) begin
      ref_armed <= 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic exp_v;
      exp_v = (ref_left > 0) ? pol : ~pol;
      n_vec++;
      if (pulse_o !== exp_v) begin
        n_bad++;
        $display("FAIL %s t=%0t pulse_o=%b expected=%b", tag, $time, pulse_o, exp_v);
      end
    end
  end

  task automatic cyc(input bit s, input bit r, input bit st);
    @(posedge clk); #2;
    sync_edge = s; ck_rise = r; ck_stopped = st;
  endtask

  task automatic run_clock(input int cycles, input int period);
    for (int i = 0; i < cycles; i++) cyc(1'b0, (i % period) == period - 1, 1'b0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tag = "R6";
    repeat (4) cyc(1'b1, 1'b1, 1'b0);
    @(posedge clk); #2; rst_n = 1'b1;
    run_clock(6, 3);

    for (int p = 1; p >= 0; p--) begin
      pol = p[0];
      for (int w = 0; w < 4; w++) begin
        tag = (p == 1) ? "R2" : "R3";
        width_code = w[1:0];
        cyc(1'b1, 1'b0, 1'b0);
        run_clock(2 ** (w + 1) * 3 + 12, 3);
      end
    end

    tag = "R1";
    pol = 1'b1; width_code = 2'd1;
    cyc(1'b1, 1'b1, 1'b0);
    run_clock(20, 2);

    tag = "R2";
    width_code = 2'd0;
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    width_code = 2'd3;
    run_clock(20, 2);

    tag = "R4";
    width_code = 2'd0;
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    run_clock(12, 2);

    tag = "R5";
    width_code = 2'd2;
    cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 30; i++) cyc(i % 3 == 0, i % 2 == 1, 1'b0);
    run_clock(20, 2);

    tag = "R7";
    width_code = 2'd1;
    cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) cyc(1'b0, (i % 7 == 1) || (i % 5 == 0), 1'b0);

    tag = "R8";
    width_code = 2'd0;
    cyc(1'b1, 1'b0, 1'b0);
    run_clock(30, 2);

    tag = "R6";
    width_code = 2'd3;
    cyc(1'b1, 1'b0, 1'b0);
    run_clock(6, 2);
    @(posedge clk); #2; rst_n = 1'b0;
    run_clock(3, 1);
    @(posedge clk); #2; rst_n = 1'b1;
    run_clock(10, 2);

    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      if (i % 400 == 0) begin pol = $urandom_range(1, 0); width_code = 2'($urandom_range(3, 0)); end
      cyc(($urandom_range(15, 0) == 0), ($urandom_range(2, 0) == 0), ($urandom_range(4, 0) == 0));
    end

    @(negedge clk); #1;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule